// File: doc/BRIEF.md
# Keyboard Game Command Decoder

This block listens to a keyboard's two-wire serial link (clock and data, both driven by the keyboard). It samples both lines with the system clock and frames each 11-bit transfer into a scancode byte. Every accepted byte is presented on `code_o` together with a one-cycle `byte_stb_o` strobe that can be routed to an interrupt controller. Software can then react to input without polling.

On top of the byte receiver the block follows the key-release sequence. A release is reported as the `0xF0` prefix followed by the key's code. The block also tracks which of five game keys are down and turns them into commands. Two keys drive level outputs for holding the ship up or down. Three keys drive one-cycle pulses for fire, pause toggle and game reset. A pulse is issued only on the first press, so the keyboard's automatic repeats of a held key add nothing. Bytes behind the `0xE0` extended prefix are swallowed.

Top module: `kbd_cmd_decoder`

## Requirements
- R1: A frame is start bit 0, eight data bits least significant first, an odd parity bit and a stop bit 1. Bits are taken on falling edges of the synchronised keyboard clock. A good frame gives exactly one `byte_stb_o` pulse, and `code_o` holds the byte from that pulse until the next good frame.
- R2: A frame whose parity is even or whose stop bit is 0 gives no `byte_stb_o` and has no effect on any command output.
- R3: If the keyboard clock stays high for `TIMEOUT_CYC` system cycles in the middle of a frame, the partial frame is discarded. The next frame is then received intact.
- R4: `up_held_o` is 1 from the press of code `0x1D` until its release. `down_held_o` does the same for code `0x1B`.
- R5: A byte that follows `0xF0` is a release of that key. It clears the key's held state and never produces a pulse.
- R6: Code `0x29` pulses `fire_o`, `0x4D` pulses `pause_o` and `0x76` pulses `reset_game_o`. Each pulse is one cycle long and comes only on a press of a key that is not already held. Repeated make codes give no further pulse.
- R7: After `0xE0`, the next code, or the `0xF0` and code pair, changes no command output. The byte after that is decoded normally.
- R8: Any other code changes no command output. It is still strobed on `byte_stb_o`.
- R9: After reset all outputs are 0 and no key is held.
- R10: At most one of `fire_o`, `pause_o` and `reset_game_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | Keyboard clock line, asynchronous |
| ps2_data_i | input | 1 | Keyboard data line, asynchronous |
| up_held_o | output | 1 | Up key held |
| down_held_o | output | 1 | Down key held |
| fire_o | output | 1 | One-cycle fire command |
| pause_o | output | 1 | One-cycle pause toggle command |
| reset_game_o | output | 1 | One-cycle game reset command |
| byte_stb_o | output | 1 | One-cycle strobe per accepted byte |
| code_o | output | 8 | Last accepted byte |

## Verification
A stuck release or extended prefix shows on the next key byte. The bench sees it as a hold level that does not clear, or as a command that is dropped or wrongly issued. A misaligned bit counter corrupts the very next frame, so `code_o` is wrong or the strobe goes missing. Every byte is followed by a check at the ports within one half keyboard-clock period, so any of these faults is caught at the byte that exposes it.

// File: rtl/kbd_cmd_pkg.sv
package kbd_cmd_pkg;
  localparam int unsigned NUM_KEYS = 5;

  typedef enum logic [2:0] {
    KEY_UP    = 3'd0,
    KEY_DOWN  = 3'd1,
    KEY_FIRE  = 3'd2,
    KEY_PAUSE = 3'd3,
    KEY_RESET = 3'd4
  } key_e;

  localparam logic [7:0] CODE_UP    = 8'h1D;
  localparam logic [7:0] CODE_DOWN  = 8'h1B;
  localparam logic [7:0] CODE_FIRE  = 8'h29;
  localparam logic [7:0] CODE_PAUSE = 8'h4D;
  localparam logic [7:0] CODE_RESET = 8'h76;
  localparam logic [7:0] CODE_BREAK = 8'hF0;
  localparam logic [7:0] CODE_EXT   = 8'hE0;

  typedef struct packed {
    logic hit;
    key_e key;
  } key_hit_t;

  function automatic key_hit_t lookup_key(logic [7:0] code);
    key_hit_t r;
    r.hit = 1'b1;
    r.key = KEY_UP;
    unique case (code)
      CODE_UP:    r.key = KEY_UP;
      CODE_DOWN:  r.key = KEY_DOWN;
      CODE_FIRE:  r.key = KEY_FIRE;
      CODE_PAUSE: r.key = KEY_PAUSE;
      CODE_RESET: r.key = KEY_RESET;
      default:    r.hit = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ps2_clk_i,
  input  logic ps2_data_i,
  output logic data_o,
  output logic fall_o
);
  logic [STAGES-1:0] clk_sr, dat_sr;
  logic              clk_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sr   <= '1;
      dat_sr   <= '1;
      clk_prev <= 1'b1;
    end else begin
      clk_sr   <= {clk_sr[STAGES-2:0], ps2_clk_i};
      dat_sr   <= {dat_sr[STAGES-2:0], ps2_data_i};
      clk_prev <= clk_sr[STAGES-1];
    end
  end

  assign fall_o = clk_prev & ~clk_sr[STAGES-1];
  assign data_o = dat_sr[STAGES-1];

  // R1: a falling edge is an isolated one-cycle event
  p_fall_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
  parameter int unsigned TIMEOUT_CYC = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fall_i,
  input  logic       data_i,
  output logic       vld_o,
  output logic [7:0] byte_o
);
  localparam int unsigned IW       = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned LAST_BIT = 10;

  logic [3:0]    bit_cnt;
  logic [7:0]    shreg;
  logic          par_q;
  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      par_q    <= 1'b0;
      idle_cnt <= '0;
      vld_o    <= 1'b0;
      byte_o   <= '0;
    end else begin
      vld_o <= 1'b0;
      if (fall_i) begin
        idle_cnt <= '0;
        if (bit_cnt == 4'd0) begin
          if (!data_i) bit_cnt <= 4'd1;
        end else if (bit_cnt == 4'd9) begin
          par_q   <= data_i;
          bit_cnt <= bit_cnt + 4'd1;
        end else if (bit_cnt == 4'(LAST_BIT)) begin
          bit_cnt <= '0;
          if (data_i && (^{shreg, par_q})) begin
            vld_o  <= 1'b1;
            byte_o <= shreg;
          end
        end else begin
          shreg   <= {data_i, shreg[7:1]};
          bit_cnt <= bit_cnt + 4'd1;
        end
      end else if (bit_cnt != 4'd0) begin
        if (idle_cnt == IW'(TIMEOUT_CYC - 1)) begin
          bit_cnt  <= '0;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end
    end
  end

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= 4'(LAST_BIT));
  // R1/R2: a byte is only accepted on the edge that closes a frame
  p_vld_after_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(fall_i) && $past(data_i) && bit_cnt == 4'd0);
  // R3: an expired idle window drops the partial frame
  p_timeout_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && bit_cnt != 4'd0 && idle_cnt == IW'(TIMEOUT_CYC - 1)) |=> bit_cnt == 4'd0);
endmodule

// File: rtl/kbd_key_map.sv
module kbd_key_map
  import kbd_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vld_i,
  input  logic [7:0] code_i,
  output logic       up_held_o,
  output logic       down_held_o,
  output logic       fire_o,
  output logic       pause_o,
  output logic       reset_game_o
);
  logic [NUM_KEYS-1:0] held;
  logic                brk_q, ext_q;
  logic                fire_q, pause_q, rst_q;
  key_hit_t            kh;

  assign kh = lookup_key(code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held    <= '0;
      brk_q   <= 1'b0;
      ext_q   <= 1'b0;
      fire_q  <= 1'b0;
      pause_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      fire_q  <= 1'b0;
      pause_q <= 1'b0;
      rst_q   <= 1'b0;
      if (vld_i) begin
        if (code_i == CODE_EXT) begin
          ext_q <= 1'b1;
        end else if (code_i == CODE_BREAK) begin
          brk_q <= 1'b1;
        end else begin
          brk_q <= 1'b0;
          ext_q <= 1'b0;
          if (!ext_q && kh.hit) begin
            if (brk_q) begin
              held[kh.key] <= 1'b0;
            end else begin
              held[kh.key] <= 1'b1;
              if (!held[kh.key]) begin
                fire_q  <= (kh.key == KEY_FIRE);
                pause_q <= (kh.key == KEY_PAUSE);
                rst_q   <= (kh.key == KEY_RESET);
              end
            end
          end
        end
      end
    end
  end

  assign up_held_o    = held[KEY_UP];
  assign down_held_o  = held[KEY_DOWN];
  assign fire_o       = fire_q;
  assign pause_o      = pause_q;
  assign reset_game_o = rst_q;

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fire_o, pause_o, reset_game_o}));
  p_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o || pause_o || reset_game_o) |=> !(fire_o || pause_o || reset_game_o));
  // R5: a release never yields a command pulse
  p_no_pulse_on_break_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && brk_q) |=> !(fire_o || pause_o || reset_game_o));
  // R7: an extended code leaves holds untouched
  p_ext_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && ext_q) |=> $stable(held));
endmodule

// File: rtl/kbd_cmd_decoder.sv
module kbd_cmd_decoder #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  output logic       up_held_o,
  output logic       down_held_o,
  output logic       fire_o,
  output logic       pause_o,
  output logic       reset_game_o,
  output logic       byte_stb_o,
  output logic [7:0] code_o
);
  logic       s_data, s_fall;
  logic       rx_vld;
  logic [7:0] rx_byte;

  kbd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ps2_clk_i, .ps2_data_i,
    .data_o(s_data), .fall_o(s_fall)
  );

  kbd_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
    .clk_i, .rst_ni, .fall_i(s_fall), .data_i(s_data),
    .vld_o(rx_vld), .byte_o(rx_byte)
  );

  kbd_key_map u_map (
    .clk_i, .rst_ni, .vld_i(rx_vld), .code_i(rx_byte),
    .up_held_o, .down_held_o, .fire_o, .pause_o, .reset_game_o
  );

  assign byte_stb_o = rx_vld;
  assign code_o     = rx_byte;

  // R1: strobe lasts one cycle
  p_stb_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_stb_o |=> !byte_stb_o);
  // R6: a command pulse always follows a strobed byte
  p_cmd_after_stb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o || pause_o || reset_game_o) |-> $past(byte_stb_o));
endmodule

// File: tb/kbd_cmd_decoder_bench.sv
`timescale 1ns/1ps
module kbd_cmd_decoder_bench;
  localparam int HP   = 20;
  localparam int TOUT = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic kclk = 1'b1, kdat = 1'b1;
  logic up, down, fire, pause, rgame, stb;
  logic [7:0] code;

  always #5 clk = ~clk;

  kbd_cmd_decoder #(.TIMEOUT_CYC(TOUT)) u_kbd_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .ps2_clk_i(kclk), .ps2_data_i(kdat),
    .up_held_o(up), .down_held_o(down), .fire_o(fire), .pause_o(pause),
    .reset_game_o(rgame), .byte_stb_o(stb), .code_o(code)
  );

  int n_cmp = 0, n_bad = 0;
  int c_stb = 0, c_fire = 0, c_pause = 0, c_rst = 0;

  always @(posedge clk) begin
    if (stb)   c_stb++;
    if (fire)  c_fire++;
    if (pause) c_pause++;
    if (rgame) c_rst++;
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_bits(logic [10:0] bits, int nb);
    for (int i = 0; i < nb; i++) begin
      kdat = bits[i];
      wait_cyc(HP);
      kclk = 1'b0;
      wait_cyc(HP);
      kclk = 1'b1;
    end
    kdat = 1'b1;
  endtask

  task automatic send_byte(logic [7:0] b, bit bad_par = 0, bit bad_stop = 0);
    logic par;
    par = (~^b) ^ bad_par;
    send_bits({~bad_stop, par, b, 1'b0}, 11);
    wait_cyc(4);
  endtask

  // {code, up, down, fire_inc, pause_inc, rst_inc}
  localparam int NV = 27;
  localparam logic [12:0] VEC [NV] = '{
    {8'h1D, 5'b10000}, {8'h1D, 5'b10000}, {8'h1B, 5'b11000},
    {8'hF0, 5'b11000}, {8'h1D, 5'b01000}, {8'h29, 5'b01100},
    {8'h29, 5'b01000}, {8'hF0, 5'b01000}, {8'h29, 5'b01000},
    {8'h29, 5'b01100}, {8'h4D, 5'b01010}, {8'h4D, 5'b01000},
    {8'hF0, 5'b01000}, {8'h4D, 5'b01000}, {8'h76, 5'b01001},
    {8'hF0, 5'b01000}, {8'h76, 5'b01000}, {8'hF0, 5'b01000},
    {8'h1B, 5'b00000}, {8'hE0, 5'b00000}, {8'h1D, 5'b00000},
    {8'hE0, 5'b00000}, {8'hF0, 5'b00000}, {8'h1D, 5'b00000},
    {8'h1D, 5'b10000}, {8'hAA, 5'b10000}, {8'hF0, 5'b10000}
  };

  initial begin
    int s0, f0, p0, r0;
    wait_cyc(3);
    // R9 reset state
    chk("R9 up", up, 0); chk("R9 down", down, 0); chk("R9 stb", stb, 0);
    chk("R9 pulses", fire | pause | rgame, 0); chk("R9 code", code, 0);
    rst_n = 1'b1;
    wait_cyc(3);

    for (int i = 0; i < NV; i++) begin
      s0 = c_stb; f0 = c_fire; p0 = c_pause; r0 = c_rst;
      send_byte(VEC[i][12:5]);
      chk("R1 strobe", c_stb - s0, 1);
      chk("R1 code", code, VEC[i][12:5]);
      chk("R4/R5/R7/R8 up", up, VEC[i][4]);
      chk("R4/R5/R7/R8 down", down, VEC[i][3]);
      chk("R6/R5 fire", c_fire - f0, VEC[i][2]);
      chk("R6 pause", c_pause - p0, VEC[i][1]);
      chk("R6 reset", c_rst - r0, VEC[i][0]);
    end
    // release of 0x1D after final F0
    send_byte(8'h1D);
    chk("R5 up released", up, 0);

    // R2: bad parity then bad stop
    s0 = c_stb; f0 = c_fire;
    send_byte(8'h29, 1, 0);
    chk("R2 parity strobe", c_stb - s0, 0);
    chk("R2 parity fire", c_fire - f0, 0);
    send_byte(8'h29, 0, 1);
    chk("R2 stop strobe", c_stb - s0, 0);
    chk("R2 stop fire", c_fire - f0, 0);
    chk("R2 code kept", code, 8'h1D);

    // R3: partial frame, idle beyond timeout, then clean frame
    send_bits(11'b000_0101_0010, 4);
    wait_cyc(TOUT + 20);
    s0 = c_stb; p0 = c_pause;
    send_byte(8'h4D);
    chk("R3 strobe", c_stb - s0, 1);
    chk("R3 code", code, 8'h4D);
    chk("R3 pause", c_pause - p0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait_cyc(150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule